// File: doc/BRIEF.md
# Cache RAM Debug Readout Unit

This unit lets privileged debug software look inside the instruction-cache RAMs of a small processor. Software writes one 32-bit selector word to an index register through a system-register write port. The top byte of that word names the target array, and the lower fields give the way and the set or row. The unit then runs a single-cycle read of the chosen array through its own RAM read port. It latches what comes back into read-only holding registers, which software fetches through a separate system-register read port.

Two arrays are modelled: a 4-way tag array, whose entries carry a tag and a valid bit, and a 4-way data array, whose entries are 64 bits wide. Results land in three instruction-side holding registers. Three data-side holding registers also exist and share the read port. Every access on either port is checked against the privilege input, and only the top level (value 3) is allowed. An access at any lower level raises an undefined-instruction flag in the same cycle, reads as zero, and changes nothing.

A controller sequences each lookup through three states. IDLE waits for an accepted index write. ISSUE drives the enable of the selected RAM. LATCH captures the returned word. The transitions are named as follows. START goes from IDLE to ISSUE on an accepted index write with a known array code. CLEAR stays in IDLE and zeroes the results for an unknown code. FETCH goes from ISSUE to LATCH. DONE goes from LATCH to IDLE.

Top module: `cram_dbg_top`

## Requirements
- R1: After reset, the index register and all six holding registers read as zero, and `busy` is low.
- R2: When the array code (written bits [31:24]) is 0x00, the tag array is read at address {way = bits [19:18], set = bits [13:6]}. Holding register I0 then holds the returned word zero-extended, with the valid bit at bit TAG_W and the tag below it. I1 and I2 read zero.
- R3: When the array code is 0x01, the data array is read at address {way = bits [19:18], row = bits [13:3]}. I0 then holds bits [31:0] of the returned 64-bit word, I1 holds bits [63:32], and I2 reads zero.
- R4: Written bits [23:20] and [17:14] are ignored. For a data read, bits [2:0] are also ignored, and for a tag read bits [5:0] are too. Setting them gives the same result as leaving them clear.
- R5: When the array code is any value other than 0x00 or 0x01, no RAM enable is raised and `busy` stays low. At that same edge all six holding registers are cleared to zero.
- R6: `busy` is high for exactly the two cycles between an accepted index write and the capture. A holding-register read during those cycles returns the previous contents.
- R7: A read or write made with `priv` not equal to 3 raises `undef` in the same cycle. Such a read returns zero. Such a write leaves the index unchanged, raises no RAM enable and does not set `busy`.
- R8: Writes to addresses 1 through 6 have no effect. They change no holding register and start no RAM read.
- R9: Read addresses are 0 for the index register (the full written value), 1 to 3 for I0 to I2, and 4 to 6 for D0 to D2. Address 7 reads zero.
- R10: An index write that arrives while `busy` is high is ignored. The running lookup completes with the original selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Privilege level of the current access, 3 = highest |
| wr_en | input | 1 | System-register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | System-register read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, combinational from the address |
| undef | output | 1 | Undefined-instruction flag for an under-privileged access |
| busy | output | 1 | A RAM lookup is in flight |
| tag_en | output | 1 | Tag array read enable |
| tag_addr | output | 10 | Tag array address {way, set} |
| tag_rdata | input | TAG_W+1 | Tag array read data, valid in the MSB, one cycle after enable |
| data_en | output | 1 | Data array read enable |
| data_addr | output | 13 | Data array address {way, row} |
| data_rdata | input | 64 | Data array read data, one cycle after enable |

## Verification
The lookup is tried with both array codes, with different way and set or row values, and with the reserved fields clear and then fully set. The bench RAM models return address-dependent words, so a wrong bit slice shows up as a wrong holding value, not as a coincidental match. An unknown array code is written after holding registers have been loaded with nonzero data, which tells clearing apart from a plain skip of the RAM access. Writes below the top privilege level, writes to the read-only addresses and a second index write during `busy` are each followed by readback and a count of RAM enables, which separates an ignored access from one that quietly altered state.

// File: rtl/cram_dbg_pkg.sv
package cram_dbg_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int ID_MSB   = 31;
    localparam int ID_LSB   = 24;
    localparam int WAY_MSB  = 19;
    localparam int WAY_LSB  = 18;
    localparam int LOC_MSB  = 13;
    localparam int ROW_LSB  = 3;
    localparam int SET_LSB  = 6;
    localparam int ID_W     = ID_MSB - ID_LSB + 1;
    localparam int WAY_W    = WAY_MSB - WAY_LSB + 1;
    localparam int ROW_W    = LOC_MSB - ROW_LSB + 1;
    localparam int SET_W    = LOC_MSB - SET_LSB + 1;
    localparam int SET_OFS  = SET_LSB - ROW_LSB;
    localparam int DATA_W   = 2 * REG_W;
    localparam int NRES     = 3;

    localparam logic [1:0]        EL_TOP    = 2'd3;
    localparam logic [ID_W-1:0]   ID_TAG    = 8'h00;
    localparam logic [ID_W-1:0]   ID_DATA   = 8'h01;
    localparam logic [ADDR_W-1:0] A_INDEX   = 3'd0;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_LATCH} state_t;
    typedef enum logic [1:0] {K_NONE, K_TAG, K_DATA} kind_t;

    function automatic kind_t kind_of(input logic [ID_W-1:0] id);
        if (id == ID_TAG)       return K_TAG;
        else if (id == ID_DATA) return K_DATA;
        else                    return K_NONE;
    endfunction
endpackage

// File: rtl/cram_dbg_decode.sv
module cram_dbg_decode
    import cram_dbg_pkg::*;
(
    input  logic [ID_W-1:0]        id,
    input  logic [WAY_W-1:0]       way,
    input  logic [ROW_W-1:0]       loc,
    output kind_t                  kind,
    output logic [WAY_W+SET_W-1:0] tag_addr,
    output logic [WAY_W+ROW_W-1:0] data_addr
);
    always_comb begin
        kind      = kind_of(id);
        tag_addr  = {way, loc[ROW_W-1:SET_OFS]};
        data_addr = {way, loc};
    end
endmodule

// File: rtl/cram_dbg_fsm.sv
module cram_dbg_fsm
    import cram_dbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  kind_t start_kind,
    input  kind_t cur_kind,
    output logic  busy,
    output logic  tag_en,
    output logic  data_en,
    output logic  cap_tag,
    output logic  cap_data,
    output logic  clr_all
);
    state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start && start_kind != K_NONE) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        tag_en   = 1'b0;
        data_en  = 1'b0;
        cap_tag  = 1'b0;
        cap_data = 1'b0;
        clr_all  = 1'b0;
        unique case (state)
            ST_IDLE:  clr_all = start && start_kind == K_NONE;
            ST_ISSUE: begin
                busy    = 1'b1;
                tag_en  = cur_kind == K_TAG;
                data_en = cur_kind == K_DATA;
            end
            ST_LATCH: begin
                busy     = 1'b1;
                cap_tag  = cur_kind == K_TAG;
                cap_data = cur_kind == K_DATA;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cram_dbg_regs.sv
module cram_dbg_regs
    import cram_dbg_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_tag,
    input  logic              cap_data,
    input  logic              clr_all,
    input  logic [TAG_W:0]    tag_rdata,
    input  logic [DATA_W-1:0] data_rdata,
    input  logic [REG_W-1:0]  index_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_mux
);
    logic [REG_W-1:0] ires [NRES];
    logic [REG_W-1:0] dres [NRES];
    logic [REG_W-1:0] tag_word;

    always_comb begin
        tag_word = '0;
        tag_word[TAG_W:0] = tag_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            ires[0] <= '0;
            ires[1] <= '0;
            ires[2] <= '0;
        end else if (cap_tag) begin
            ires[0] <= tag_word;
            ires[1] <= '0;
            ires[2] <= '0;
        end else if (cap_data) begin
            ires[0] <= data_rdata[REG_W-1:0];
            ires[1] <= data_rdata[DATA_W-1:REG_W];
            ires[2] <= '0;
        end
    end

    for (genvar g = 0; g < NRES; g++) begin : g_dres
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) dres[g] <= '0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_mux = index_q;
            3'd1:    rd_mux = ires[0];
            3'd2:    rd_mux = ires[1];
            3'd3:    rd_mux = ires[2];
            3'd4:    rd_mux = dres[0];
            3'd5:    rd_mux = dres[1];
            3'd6:    rd_mux = dres[2];
            default: rd_mux = '0;
        endcase
    end
endmodule

// File: rtl/cram_dbg_top.sv
module cram_dbg_top
    import cram_dbg_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               priv,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [REG_W-1:0]         rd_data,
    output logic                     undef,
    output logic                     busy,
    output logic                     tag_en,
    output logic [WAY_W+SET_W-1:0]   tag_addr,
    input  logic [TAG_W:0]           tag_rdata,
    output logic                     data_en,
    output logic [WAY_W+ROW_W-1:0]   data_addr,
    input  logic [DATA_W-1:0]        data_rdata
);
    logic             allowed, start, cap_tag, cap_data, clr_all;
    logic [REG_W-1:0] index_q, rd_mux;
    kind_t            cur_kind, start_kind;

    assign allowed    = priv == EL_TOP;
    assign undef      = (wr_en || rd_en) && !allowed;
    assign start      = wr_en && allowed && wr_addr == A_INDEX && !busy;
    assign start_kind = kind_of(wr_data[ID_MSB:ID_LSB]);
    assign rd_data    = (rd_en && allowed) ? rd_mux : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)     index_q <= '0;
        else if (start) index_q <= wr_data;
    end

    cram_dbg_decode u_dec (
        .id        (index_q[ID_MSB:ID_LSB]),
        .way       (index_q[WAY_MSB:WAY_LSB]),
        .loc       (index_q[LOC_MSB:ROW_LSB]),
        .kind      (cur_kind),
        .tag_addr  (tag_addr),
        .data_addr (data_addr)
    );

    cram_dbg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .cur_kind   (cur_kind),
        .busy       (busy),
        .tag_en     (tag_en),
        .data_en    (data_en),
        .cap_tag    (cap_tag),
        .cap_data   (cap_data),
        .clr_all    (clr_all)
    );

    cram_dbg_regs #(.TAG_W(TAG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_tag    (cap_tag),
        .cap_data   (cap_data),
        .clr_all    (clr_all),
        .tag_rdata  (tag_rdata),
        .data_rdata (data_rdata),
        .index_q    (index_q),
        .rd_addr    (rd_addr),
        .rd_mux     (rd_mux)
    );
endmodule

// File: rtl/cram_dbg_chk.sv
module cram_dbg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  priv,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic        undef,
    input logic        busy,
    input logic        tag_en,
    input logic        data_en
);
    a_r2_one_array: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tag_en, data_en}));

    a_r5_unknown_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && priv == 2'd3 && !busy && wr_data[31:24] > 8'h01)
        |=> (!busy && !tag_en && !data_en));

    a_r6_en_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en || data_en) |-> busy);

    a_r6_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    a_r7_denied_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && priv != 2'd3 && !busy) |=> !busy);

    a_r7_undef_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && priv != 2'd3) |-> undef);

    a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 3'd0 && !busy) |=> !busy);
endmodule

bind cram_dbg_top cram_dbg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .priv    (priv),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .undef   (undef),
    .busy    (busy),
    .tag_en  (tag_en),
    .data_en (data_en)
);

// File: tb/tb_cram_dbg_top.sv
module tb_cram_dbg_top;
    localparam int TAG_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        undef, busy, tag_en, data_en;
    logic [9:0]  tag_addr;
    logic [12:0] data_addr;
    logic [TAG_W:0] tag_rdata = '0;
    logic [63:0] data_rdata = '0;

    int checks = 0;
    int errors = 0;
    int en_cnt = 0;

    always #10 clk = ~clk;

    cram_dbg_top #(.TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .priv(priv),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .undef(undef), .busy(busy),
        .tag_en(tag_en), .tag_addr(tag_addr), .tag_rdata(tag_rdata),
        .data_en(data_en), .data_addr(data_addr), .data_rdata(data_rdata)
    );

    function automatic logic [TAG_W:0] f_tag(input logic [9:0] a);
        return {a[0], 24'(a) * 24'd7 + 24'h001234};
    endfunction

    function automatic logic [63:0] f_data(input logic [12:0] a);
        return {32'(a) ^ 32'hCAFE0000, 32'(a) * 32'h00010001 + 32'd1};
    endfunction

    always @(posedge clk) begin
        if (tag_en)  tag_rdata  <= f_tag(tag_addr);
        if (data_en) data_rdata <= f_data(data_addr);
        if (rst_n && (tag_en || data_en)) en_cnt <= en_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] p,
                      output logic [31:0] d, output logic u);
        rd_en = 1'b1; rd_addr = a; priv = p;
        #1;
        d = rd_data; u = undef;
        rd_en = 1'b0; priv = 2'd3;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v,
                      input logic [1:0] p, output logic u);
        wr_en = 1'b1; wr_addr = a; wr_data = v; priv = p;
        #1;
        u = undef;
        @(negedge clk);
        wr_en = 1'b0; priv = 2'd3;
    endtask

    function automatic logic [31:0] exp_tag(input logic [31:0] v);
        return 32'(f_tag({v[19:18], v[13:6]}));
    endfunction

    function automatic logic [63:0] exp_data(input logic [31:0] v);
        return f_data({v[19:18], v[13:3]});
    endfunction

    task automatic t_reset;
        logic [31:0] d; logic u;
        chk("R1 busy", 32'(busy), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), 2'd3, d, u);
            chk(a == 7 ? "R9 addr7" : "R1 reset value", d, 0);
        end
    endtask

    task automatic run_lookup(input logic [31:0] v, input logic [31:0] e0,
                              input logic [31:0] e1, input string req);
        logic [31:0] d, old0; logic u;
        rd(3'd1, 2'd3, old0, u);
        wr(3'd0, v, 2'd3, u);
        chk("R7 no undef at top", 32'(u), 0);
        chk("R6 busy first", 32'(busy), 1);
        rd(3'd1, 2'd3, d, u);
        chk("R6 old contents", d, old0);
        @(negedge clk);
        chk("R6 busy second", 32'(busy), 1);
        @(negedge clk);
        chk("R6 busy low", 32'(busy), 0);
        rd(3'd1, 2'd3, d, u); chk(req, d, e0);
        rd(3'd2, 2'd3, d, u); chk(req, d, e1);
        rd(3'd3, 2'd3, d, u); chk(req, d, 0);
        rd(3'd0, 2'd3, d, u); chk("R9 index readback", d, v);
    endtask

    task automatic t_tag;
        logic [31:0] v = (32'd2 << 18) | (32'hA5 << 6);
        run_lookup(v, exp_tag(v), 0, "R2 tag read");
        v = (32'd1 << 18) | (32'h3C << 6);
        run_lookup(v, exp_tag(v), 0, "R2 tag read way1");
    endtask

    task automatic t_data;
        logic [31:0] v = 32'h0100_0000 | (32'd3 << 18) | (32'h5AB << 3);
        logic [63:0] e = exp_data(v);
        run_lookup(v, e[31:0], e[63:32], "R3 data read");
    endtask

    task automatic t_reserved;
        logic [31:0] v = (32'd2 << 18) | (32'hA5 << 6);
        logic [63:0] e;
        run_lookup(v | 32'h00F3_C03F, exp_tag(v), 0, "R4 tag reserved");
        v = 32'h0100_0000 | (32'd1 << 18) | (32'h2D6 << 3);
        e = exp_data(v);
        run_lookup(v | 32'h00F3_C007, e[31:0], e[63:32], "R4 data reserved");
    endtask

    task automatic t_unknown;
        logic [31:0] d; logic u; int n0 = en_cnt;
        wr(3'd0, 32'h5A04_1234, 2'd3, u);
        chk("R5 busy stays low", 32'(busy), 0);
        @(negedge clk);
        chk("R5 no RAM enable", 32'(en_cnt), 32'(n0));
        for (int a = 1; a < 7; a++) begin
            rd(3'(a), 2'd3, d, u);
            chk("R5 cleared", d, 0);
        end
    endtask

    task automatic t_priv;
        logic [31:0] d, idx; logic u; int n0;
        logic [31:0] v = (32'd1 << 18) | (32'h11 << 6);
        run_lookup(v, exp_tag(v), 0, "R2 reload");
        n0 = en_cnt;
        rd(3'd0, 2'd3, idx, u);
        wr(3'd0, (32'd3 << 18) | (32'h77 << 6), 2'd1, u);
        chk("R7 write undef", 32'(u), 1);
        chk("R7 no busy", 32'(busy), 0);
        @(negedge clk);
        chk("R7 no RAM enable", 32'(en_cnt), 32'(n0));
        rd(3'd0, 2'd3, d, u);
        chk("R7 index unchanged", d, idx);
        rd(3'd1, 2'd2, d, u);
        chk("R7 read zero", d, 0);
        chk("R7 read undef", 32'(u), 1);
        rd(3'd1, 2'd3, d, u);
        chk("R7 top read no undef", 32'(u), 0);
        chk("R7 contents kept", d, exp_tag(v));
    endtask

    task automatic t_readonly;
        logic [31:0] d, o1; logic u; int n0 = en_cnt;
        rd(3'd1, 2'd3, o1, u);
        wr(3'd1, 32'hFFFF_FFFF, 2'd3, u);
        chk("R8 no busy", 32'(busy), 0);
        wr(3'd5, 32'h1234_5678, 2'd3, u);
        @(negedge clk);
        chk("R8 no RAM enable", 32'(en_cnt), 32'(n0));
        rd(3'd1, 2'd3, d, u); chk("R8 I0 kept", d, o1);
        rd(3'd5, 2'd3, d, u); chk("R8 D1 kept", d, 0);
    endtask

    task automatic t_busy_write;
        logic [31:0] d; logic u;
        logic [31:0] v1 = (32'd0 << 18) | (32'h42 << 6);
        logic [31:0] v2 = 32'h0100_0000 | (32'd2 << 18) | (32'h123 << 3);
        wr(3'd0, v1, 2'd3, u);
        wr(3'd0, v2, 2'd3, u);
        @(negedge clk);
        chk("R10 busy done", 32'(busy), 0);
        rd(3'd1, 2'd3, d, u); chk("R10 first result", d, exp_tag(v1));
        rd(3'd0, 2'd3, d, u); chk("R10 index kept", d, v1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tag();
        t_data();
        t_reserved();
        t_unknown();
        t_priv();
        t_readonly();
        t_busy_write();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule